// File: doc/BRIEF.md
# Sectored Queue Flag Status Bus

This block presents status flags for sixteen queues over a narrow shared bus. Each queue has one status input, asserted high when that queue is in the flagged condition (for example almost-full or almost-empty). The queues are grouped into sectors of eight. On each clock edge the block registers the flags of one sector onto an eight-bit bus. The bus is active low, and the block also reports which sector it is showing.

Two modes are available, and the level of a mode input sampled while reset is held picks between them. In direct mode, a strobe together with a queue address selects the sector to display, and that choice holds until the next strobe. In polled mode, the block walks through the sectors on successive edges without any outside help. An output-enable stands in for the tri-state driver that several devices would need to share one bus. When the enable is off, the block reports that it is not driving and shows the bus as released (all ones).

Top module: `sector_flag_bus`

## Requirements
- R1: While reset is low at a clock edge, the registered bus becomes all ones and the sector output becomes 0. Both outputs keep these values until the first edge at which reset is high.
- R2: The mode input is captured only at edges where reset is low (1 = polled, 0 = direct). Changing it while reset is high has no effect on the outputs.
- R3: In direct mode, at an edge where the strobe is high, the displayed sector becomes the most significant bit of the 4-bit queue address. The address's lower 3 bits give the bit position inside the sector and play no part in the selection.
- R4: In direct mode, at an edge where the strobe is low, the sector output keeps the last selected sector. The bus reloads that sector's current flags on every edge.
- R5: In polled mode, the sector output advances by one on every edge where reset is high, wrapping from 1 back to 0. After reset the sequence is therefore 1, 0, 1, and so on. The strobe and the address have no effect in this mode.
- R6: Bus bit i equals the inverse of the status input for queue (sector × 8 + i), as sampled at the edge that loaded the bus, so a flagged queue reads 0.
- R7: When the output-enable is low, the drive output is 0 and the bus reads all ones. When it is high, the drive output is 1 and the bus shows the registered sector data. The enable never alters the sector sequence.
- R8: The sector output and the bus data change at the same clock edge, so the displayed bits always belong to the sector that is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| poll_mode_i | input | 1 | Mode select captured during reset: 1 polled, 0 direct |
| strobe_i | input | 1 | Direct-mode sector select strobe |
| qaddr_i | input | 4 | Queue address; MSB picks the sector |
| cond_i | input | 16 | Per-queue status, 1 = flagged condition |
| bus_oe_i | input | 1 | Bus output-enable |
| flag_bus_o | output | 8 | Active-low sector flag bus |
| bus_drive_o | output | 1 | High while the block drives the bus |
| sector_o | output | 1 | Index of the sector on the bus |

## Verification
The block is tried in direct mode with strobes to every queue address in turn, so that both sectors are selected through addresses whose low bits vary. This shows that only the top address bit steers the selection. Long stretches without a strobe, while the status inputs keep changing, separate a latched sector whose data is refreshed from one whose data is frozen. In polled mode, strobes and addresses are driven at random to show that they are ignored while the sector alternates. A mode change after reset, and an output-enable that toggles in both modes, show that neither disturbs the sequence. A reset in the middle of a run checks the return to sector 0 with all bits at one.

// File: rtl/sector_flag_bus.sv
module sector_flag_bus #(
  parameter int NUM_QUEUES = 16,
  parameter int SECTOR_W   = 8,
  localparam int NUM_SECT  = NUM_QUEUES / SECTOR_W,
  localparam int SEC_BITS  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int QA_BITS   = $clog2(NUM_QUEUES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  poll_mode_i,
  input  logic                  strobe_i,
  input  logic [QA_BITS-1:0]    qaddr_i,
  input  logic [NUM_QUEUES-1:0] cond_i,
  input  logic                  bus_oe_i,
  output logic [SECTOR_W-1:0]   flag_bus_o,
  output logic                  bus_drive_o,
  output logic [SEC_BITS-1:0]   sector_o
);

  logic                mode_q;
  logic [SEC_BITS-1:0] sector_q;
  logic [SEC_BITS-1:0] sector_d;
  logic [SECTOR_W-1:0] bus_q;

  always_comb begin
    if (mode_q) begin
      if (sector_q == SEC_BITS'(NUM_SECT - 1)) sector_d = '0;
      else                                      sector_d = sector_q + 1'b1;
    end else if (strobe_i) begin
      sector_d = qaddr_i[QA_BITS-1 -: SEC_BITS];
    end else begin
      sector_d = sector_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= poll_mode_i;
      sector_q <= '0;
      bus_q    <= '1;
    end else begin
      sector_q <= sector_d;
      bus_q    <= ~cond_i[sector_d*SECTOR_W +: SECTOR_W];
    end
  end

  assign sector_o    = sector_q;
  assign bus_drive_o = bus_oe_i;
  assign flag_bus_o  = bus_oe_i ? bus_q : '1;

endmodule

module sector_flag_bus_chk #(
  parameter int NUM_QUEUES = 16,
  parameter int SECTOR_W   = 8,
  parameter int SEC_BITS   = 1,
  parameter int QA_BITS    = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mode_q,
  input logic                  strobe_i,
  input logic [QA_BITS-1:0]    qaddr_i,
  input logic [NUM_QUEUES-1:0] cond_i,
  input logic [SECTOR_W-1:0]   bus_q,
  input logic [SEC_BITS-1:0]   sector_o
);

  logic [NUM_QUEUES-1:0] cond_hist;
  logic                  hist_ok;
  logic [SECTOR_W-1:0]   shown;

  always_ff @(posedge clk) begin
    cond_hist <= cond_i;
    hist_ok   <= rst_n;
  end

  always_comb shown = cond_hist[sector_o*SECTOR_W +: SECTOR_W];

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q)); // R2
  AST_DIRECT_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && strobe_i) |=> sector_o == $past(qaddr_i[QA_BITS-1 -: SEC_BITS])); // R3
  AST_DIRECT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !strobe_i) |=> $stable(sector_o)); // R4
  AST_POLL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> sector_o != $past(sector_o)); // R5
  AST_ACTIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hist_ok |-> bus_q == ~shown); // R6

endmodule

bind sector_flag_bus sector_flag_bus_chk #(
  .NUM_QUEUES(NUM_QUEUES), .SECTOR_W(SECTOR_W), .SEC_BITS(SEC_BITS), .QA_BITS(QA_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .strobe_i(strobe_i),
  .qaddr_i(qaddr_i), .cond_i(cond_i), .bus_q(bus_q), .sector_o(sector_o)
);

// File: tb/tb_sector_flag_bus.sv
module tb_sector_flag_bus;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poll_mode_i = 1'b0;
  logic        strobe_i = 1'b0;
  logic [3:0]  qaddr_i = '0;
  logic [15:0] cond_i = '0;
  logic        bus_oe_i = 1'b1;
  logic [7:0]  flag_bus_o;
  logic        bus_drive_o;
  logic [0:0]  sector_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R1";

  int m_mode = 0;
  int m_sec  = 0;
  int m_bus  = 255;

  sector_flag_bus dut (
    .clk(clk), .rst_n(rst_n), .poll_mode_i(poll_mode_i), .strobe_i(strobe_i),
    .qaddr_i(qaddr_i), .cond_i(cond_i), .bus_oe_i(bus_oe_i),
    .flag_bus_o(flag_bus_o), .bus_drive_o(bus_drive_o), .sector_o(sector_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = int'(poll_mode_i);
      m_sec  = 0;
      m_bus  = 255;
    end else begin
      if (m_mode == 1)       m_sec = (m_sec + 1) % 2;
      else if (strobe_i)     m_sec = int'(qaddr_i) / 8;
      m_bus = (~(int'(cond_i) >> (m_sec * 8))) & 255;
    end
  end

  always @(negedge clk) begin
    int exp_bus;
    exp_bus = bus_oe_i ? m_bus : 255;
    checks++;
    if (int'(flag_bus_o) != exp_bus || int'(sector_o) != m_sec ||
        bus_drive_o != bus_oe_i) begin
      fails++;
      $display("FAIL %s R8: bus=%h sec=%0d drv=%0b expected bus=%h sec=%0d drv=%0b",
               tag, flag_bus_o, sector_o, bus_drive_o, exp_bus[7:0], m_sec, bus_oe_i);
    end
  end

  task automatic step(input bit stb, input int addr, input bit oe);
    @(negedge clk); #2;
    strobe_i = stb;
    qaddr_i  = addr[3:0];
    bus_oe_i = oe;
    cond_i   = 16'($urandom);
  endtask

  task automatic do_reset(input bit pm);
    @(negedge clk); #2;
    tag = "R1"; rst_n = 1'b0; poll_mode_i = pm;
    repeat (3) step(1'b1, 15, 1'b1);
    @(negedge clk); #2;
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(7));
    do_reset(1'b0);
    tag = "R2"; poll_mode_i = 1'b1;
    repeat (6) step(1'b0, 0, 1'b1);
    tag = "R3";
    for (int a = 0; a < 16; a++) step(1'b1, a, 1'b1);
    tag = "R6";
    step(1'b1, 3, 1'b1);
    @(negedge clk); #2; strobe_i = 1'b0; cond_i = 16'h00A5;
    @(negedge clk); #2; cond_i = 16'h5A00;
    step(1'b1, 12, 1'b1);
    tag = "R4";
    repeat (20) step(1'b0, 5, 1'b1);
    tag = "R7";
    repeat (8) step(1'b0, 0, 1'b0);
    step(1'b1, 2, 1'b0);
    repeat (4) step(1'b0, 9, 1'b1);

    do_reset(1'b1);
    tag = "R5";
    for (int i = 0; i < 40; i++) step(1'($urandom), int'($urandom % 16), 1'b1);
    tag = "R7";
    for (int i = 0; i < 20; i++) step(1'b0, 0, 1'($urandom));
    tag = "R2"; poll_mode_i = 1'b0;
    repeat (10) step(1'b1, 0, 1'b1);

    tag = "R1"; @(negedge clk); #2; rst_n = 1'b0; poll_mode_i = 1'b0;
    repeat (2) step(1'b0, 0, 1'b1);
    @(negedge clk); #2; rst_n = 1'b1;
    tag = "R4";
    repeat (5) step(1'b0, 15, 1'b1);
    tag = "R3";
    repeat (5) step(1'b1, 8, 1'b1);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule